// File: doc/BRIEF.md
# Programmable Frequency Synthesizer Divider Chain

This block holds the three programmable counters of a clock synthesizer in digital form. A reference pre-divider runs on the reference clock. A feedback divider and an output post scaler both run on the oscillator clock. Each counter gives two registered outputs: a one-cycle pulse at the end of every period, and a square wave close to 50% duty. The phase comparator, the oscillator and the loop filter are outside this block. Both clocks arrive here as ordinary digital clocks.

All three divider codes sit in one packed configuration word. That word comes from one of two places: a register written on the reference clock, or a set of direct pins. A test-select input chooses the source. Each counter picks up a new code only when it wraps, so reprogramming never cuts a period short. A power-down input freezes every counter at zero and holds all outputs low. When power-down is released, all counters start again from zero. Each domain treats the reset as synchronous.

With the default widths, the output frequency is (m + 8) × f_ref / ((p + 2) × 2^s).

Top module: `pll_div_chain`

## Requirements
- R1: While `rst` is high, all six divider outputs are low, and the configuration register is cleared to zero. A zero register therefore gives ratios of 2 (pre), 8 (feedback) and 1 (post).
- R2: The pre-divider divides `ref_clk` by p + P_OFS, where p is the pre-divider code. `ref_pulse` is high for one `ref_clk` cycle once per period.
- R3: The feedback divider divides `osc_clk` by m + M_OFS, where m is the feedback code. `fb_pulse` is high for one `osc_clk` cycle once per period.
- R4: The post scaler divides `osc_clk` by 2^s, where s is the scaler code. The possible ratios are 1, 2, 4 and 8. `out_pulse` marks each period.
- R5: For a ratio N ≥ 2, each square output is high for floor(N/2) cycles of its clock per period and low for the rest of the period. The high phase starts in the cycle after the pulse. For N = 1, the square output stays high.
- R6: The configuration word holds m in the top M_W bits, then p in the next P_W bits, then s in the low S_W bits. With the default widths these are [15:8], [7:2] and [1:0]. The register loads `cfg_wdata` on a `ref_clk` edge where `cfg_we` is high.
- R7: When `use_pins` is 1, the codes come from `pin_cfg`, and register contents and register writes have no effect on the outputs. When `use_pins` is 0, the codes come from the register.
- R8: A code change takes effect only at the counter's wrap. The period in progress completes at the old ratio, and the next period uses the new ratio.
- R9: While `pwrdn` is high, every divider output is low from the first clock edge onward, whatever the configuration inputs do.
- R10: After `pwrdn` falls, each counter restarts from zero using the code selected at that time. Its first pulse appears on the N-th edge of its clock that samples `pwrdn` low, and its square output goes high on the first such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the configuration register |
| osc_clk | input | 1 | Oscillator clock for the feedback divider and post scaler |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn | input | 1 | Power-down: freezes all counters at zero |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | M_W+P_W+S_W | Word to load into the configuration register |
| pin_cfg | input | M_W+P_W+S_W | Configuration word from direct pins |
| use_pins | input | 1 | 1 selects `pin_cfg`, 0 selects the register |
| ref_pulse | output | 1 | One-cycle pulse per pre-divider period |
| ref_sq | output | 1 | Square output of the pre-divider |
| fb_pulse | output | 1 | One-cycle pulse per feedback-divider period |
| fb_sq | output | 1 | Square output of the feedback divider |
| out_pulse | output | 1 | One-cycle pulse per post-scaler period |
| out_sq | output | 1 | Square output of the post scaler |

## Verification
The bench builds the chain with a 5-bit feedback code, a 4-bit pre-divider code and a 2-bit scaler code, with the offsets left at 8 and 2. This keeps every feedback ratio from 8 to 39, every pre-divider ratio from 2 to 17 and all four scaler ratios within a short run. Each of these ratios is swept in full, and the period and high time are measured against values computed from the code. The same small build also reaches the odd-ratio duty rule, the reprogram-at-wrap ordering, and the restart count after power-down for each counter.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  localparam int unsigned DEF_M_W   = 8;
  localparam int unsigned DEF_P_W   = 6;
  localparam int unsigned DEF_S_W   = 2;
  localparam int unsigned DEF_M_OFS = 8;
  localparam int unsigned DEF_P_OFS = 2;

  // Number of bits needed to hold any ratio up to max_ratio.
  function automatic int unsigned ratio_bits(input int unsigned max_ratio);
    return $clog2(max_ratio + 1);
  endfunction

  typedef enum logic {
    SRC_REG  = 1'b0,
    SRC_PINS = 1'b1
  } cfg_src_e;

endpackage

// File: rtl/pll_cfg_select.sv
module pll_cfg_select
  import pll_div_pkg::*;
#(
  parameter int unsigned M_W = DEF_M_W,
  parameter int unsigned P_W = DEF_P_W,
  parameter int unsigned S_W = DEF_S_W,
  localparam int unsigned CFG_W = M_W + P_W + S_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_word,
  input  logic [CFG_W-1:0] pin_word,
  input  logic             use_pins,
  output logic [M_W-1:0]   m_code,
  output logic [P_W-1:0]   p_code,
  output logic [S_W-1:0]   s_code
);

  localparam int unsigned M_LSB = P_W + S_W;
  localparam int unsigned P_LSB = S_W;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] word_sel;
  cfg_src_e         src;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= wr_word;
    end
  end

  assign src      = cfg_src_e'(use_pins);
  assign word_sel = (src == SRC_PINS) ? pin_word : cfg_q;

  // Field layout: main code on top, pre-divider code in the middle, scaler code at the bottom.
  assign m_code = word_sel[M_LSB +: M_W];
  assign p_code = word_sel[P_LSB +: P_W];
  assign s_code = word_sel[0 +: S_W];

endmodule

// File: rtl/pll_ratio_div.sv
module pll_ratio_div #(
  parameter int unsigned RW        = 8,
  parameter int unsigned MIN_RATIO = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pd,
  input  logic [RW-1:0] ratio,
  output logic          pulse,
  output logic          square
);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] act_q;
  logic          tc;
  logic          sq_next;

  assign tc = (cnt_q == act_q - 1'b1);

  // Counter and ratio shadow; ratio shadow reloads only at wrap or while held.
  always_ff @(posedge clk) begin
    if (rst || pd) begin
      cnt_q  <= '0;
      act_q  <= ratio;
      pulse  <= 1'b0;
      square <= 1'b0;
    end else begin
      pulse  <= tc;
      square <= sq_next;
      if (tc) begin
        cnt_q <= '0;
        act_q <= ratio;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Square wave: high for the lower half of the count, shorter half on odd ratios.
  generate
    if (MIN_RATIO <= 1) begin : g_unity
      assign sq_next = (act_q == RW'(1)) ? 1'b1 : (cnt_q < (act_q >> 1));
    end else begin : g_plain
      assign sq_next = (cnt_q < (act_q >> 1));
    end
  endgenerate

  // R9: outputs go quiet once power-down is seen
  a_r9_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    pd |=> (!pulse && !square));

  // R10: counter sits at zero after a power-down cycle
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (rst)
    pd |=> (cnt_q == '0));

  // R8: active ratio changes only at wrap or power-down
  a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
    (!pd && !tc) |=> $stable(act_q));

  // R2: count never reaches the active ratio
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < act_q));

  // R5: a pulse output always coincides with a counter back at zero
  a_r5_pulse_at_wrap: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (cnt_q == '0));

endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
  import pll_div_pkg::*;
#(
  parameter int unsigned M_W   = DEF_M_W,
  parameter int unsigned P_W   = DEF_P_W,
  parameter int unsigned S_W   = DEF_S_W,
  parameter int unsigned M_OFS = DEF_M_OFS,
  parameter int unsigned P_OFS = DEF_P_OFS
) (
  input  logic                   ref_clk,
  input  logic                   osc_clk,
  input  logic                   rst,
  input  logic                   pwrdn,
  input  logic                   cfg_we,
  input  logic [M_W+P_W+S_W-1:0] cfg_wdata,
  input  logic [M_W+P_W+S_W-1:0] pin_cfg,
  input  logic                   use_pins,
  output logic                   ref_pulse,
  output logic                   ref_sq,
  output logic                   fb_pulse,
  output logic                   fb_sq,
  output logic                   out_pulse,
  output logic                   out_sq
);

  localparam int unsigned P_RW = ratio_bits((2 ** P_W) - 1 + P_OFS);
  localparam int unsigned M_RW = ratio_bits((2 ** M_W) - 1 + M_OFS);
  localparam int unsigned S_RW = 2 ** S_W;

  logic [M_W-1:0]  m_code;
  logic [P_W-1:0]  p_code;
  logic [S_W-1:0]  s_code;
  logic [P_RW-1:0] pre_ratio;
  logic [M_RW-1:0] fb_ratio;
  logic [S_RW-1:0] post_ratio;

  pll_cfg_select #(
    .M_W (M_W),
    .P_W (P_W),
    .S_W (S_W)
  ) u_cfg (
    .clk      (ref_clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_word  (cfg_wdata),
    .pin_word (pin_cfg),
    .use_pins (use_pins),
    .m_code   (m_code),
    .p_code   (p_code),
    .s_code   (s_code)
  );

  assign pre_ratio  = P_RW'(p_code) + P_RW'(P_OFS);
  assign fb_ratio   = M_RW'(m_code) + M_RW'(M_OFS);
  assign post_ratio = S_RW'(1) << s_code;

  pll_ratio_div #(
    .RW        (P_RW),
    .MIN_RATIO (P_OFS)
  ) u_pre (
    .clk    (ref_clk),
    .rst    (rst),
    .pd     (pwrdn),
    .ratio  (pre_ratio),
    .pulse  (ref_pulse),
    .square (ref_sq)
  );

  pll_ratio_div #(
    .RW        (M_RW),
    .MIN_RATIO (M_OFS)
  ) u_fb (
    .clk    (osc_clk),
    .rst    (rst),
    .pd     (pwrdn),
    .ratio  (fb_ratio),
    .pulse  (fb_pulse),
    .square (fb_sq)
  );

  pll_ratio_div #(
    .RW        (S_RW),
    .MIN_RATIO (1)
  ) u_post (
    .clk    (osc_clk),
    .rst    (rst),
    .pd     (pwrdn),
    .ratio  (post_ratio),
    .pulse  (out_pulse),
    .square (out_sq)
  );

  // R4: the scaler pulse never fires while the feedback side is held quiet
  a_r4_post_quiet: assert property (@(posedge osc_clk) disable iff (rst)
    $past(pwrdn) |-> !out_pulse);

endmodule

// File: tb/test_pll_div_chain.sv
module test_pll_div_chain;

  localparam int CLK_PERIOD = 10;
  localparam int OSC_PERIOD = 6;
  localparam int TM_W   = 5;
  localparam int TP_W   = 4;
  localparam int TS_W   = 2;
  localparam int TCFG_W = TM_W + TP_W + TS_W;
  localparam int M_OFS  = 8;
  localparam int P_OFS  = 2;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst, pwrdn, cfg_we, use_pins;
  logic [TCFG_W-1:0] cfg_wdata, pin_cfg;
  logic ref_pulse, ref_sq, fb_pulse, fb_sq, out_pulse, out_sq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) ref_clk = ~ref_clk;
  always #(OSC_PERIOD / 2) osc_clk = ~osc_clk;

  pll_div_chain #(
    .M_W (TM_W), .P_W (TP_W), .S_W (TS_W), .M_OFS (M_OFS), .P_OFS (P_OFS)
  ) i_pll_div_chain (
    .ref_clk (ref_clk), .osc_clk (osc_clk), .rst (rst), .pwrdn (pwrdn),
    .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .pin_cfg (pin_cfg), .use_pins (use_pins),
    .ref_pulse (ref_pulse), .ref_sq (ref_sq), .fb_pulse (fb_pulse), .fb_sq (fb_sq),
    .out_pulse (out_pulse), .out_sq (out_sq)
  );

  function automatic logic [TCFG_W-1:0] word(input int m, input int p, input int s);
    return {TM_W'(m), TP_W'(p), TS_W'(s)};
  endfunction

  function automatic logic pulse_of(input int ch);
    case (ch)
      0:       return ref_pulse;
      1:       return fb_pulse;
      default: return out_pulse;
    endcase
  endfunction

  function automatic logic sq_of(input int ch);
    case (ch)
      0:       return ref_sq;
      1:       return fb_sq;
      default: return out_sq;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int ch);
    if (ch == 0) @(posedge ref_clk);
    else         @(posedge osc_clk);
    #1;
  endtask

  task automatic sync(input int ch);
    for (int i = 0; i < 400; i++) begin
      tick(ch);
      if (pulse_of(ch)) break;
    end
  endtask

  task automatic gap(input int ch, output int per, output int hi);
    per = 0;
    hi  = 0;
    for (int i = 0; i < 400; i++) begin
      tick(ch);
      per++;
      if (sq_of(ch)) hi++;
      if (pulse_of(ch)) break;
    end
  endtask

  task automatic measure(input int ch, output int per, output int hi);
    sync(ch);
    sync(ch);
    gap(ch, per, hi);
  endtask

  int per, hi, seen, n;

  initial begin
    rst = 1'b1; pwrdn = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; pin_cfg = '0; use_pins = 1'b0;
    repeat (4) tick(0);
    // R1: all outputs low during reset
    check("R1 outputs high during reset",
          int'(ref_pulse) + int'(ref_sq) + int'(fb_pulse) + int'(fb_sq) + int'(out_pulse) + int'(out_sq), 0);
    rst = 1'b0;

    // R1: cleared register gives ratios 2, 8, 1
    measure(0, per, hi); check("R1 reset pre ratio", per, 2);
    measure(1, per, hi); check("R1 reset fb ratio", per, 8);
    measure(2, per, hi); check("R1 reset post ratio", per, 1);

    // R6: register write and field layout
    tick(0); cfg_wdata = word(13, 5, 2); cfg_we = 1'b1;
    tick(0); cfg_we = 1'b0;
    measure(0, per, hi); check("R6 reg pre p=5", per, 7);
    measure(1, per, hi); check("R6 reg fb m=13", per, 21);
    measure(2, per, hi); check("R6 reg post s=2", per, 4);

    // R7: pins take over; register writes then ignored; back to register
    pin_cfg = word(3, 9, 1); use_pins = 1'b1;
    tick(0); cfg_wdata = word(30, 14, 3); cfg_we = 1'b1;
    tick(0); cfg_we = 1'b0;
    measure(0, per, hi); check("R7 pins pre p=9", per, 11);
    measure(1, per, hi); check("R7 pins fb m=3", per, 11);
    measure(2, per, hi); check("R7 pins post s=1", per, 2);
    tick(0); use_pins = 1'b0;
    measure(1, per, hi); check("R7 register fb m=30", per, 38);
    measure(0, per, hi); check("R7 register pre p=14", per, 16);

    // R2/R5: all pre-divider codes
    use_pins = 1'b1;
    for (int p = 0; p < (1 << TP_W); p++) begin
      tick(0); pin_cfg = word(0, p, 0);
      measure(0, per, hi);
      check($sformatf("R2 pre period p=%0d", p), per, p + P_OFS);
      check($sformatf("R5 pre high time p=%0d", p), hi, (p + P_OFS) / 2);
    end

    // R3/R5: all feedback codes
    for (int m = 0; m < (1 << TM_W); m++) begin
      tick(1); pin_cfg = word(m, 0, 0);
      measure(1, per, hi);
      check($sformatf("R3 fb period m=%0d", m), per, m + M_OFS);
      check($sformatf("R5 fb high time m=%0d", m), hi, (m + M_OFS) / 2);
    end

    // R4/R5: all scaler codes
    for (int s = 0; s < (1 << TS_W); s++) begin
      tick(1); pin_cfg = word(0, 0, s);
      measure(2, per, hi);
      check($sformatf("R4 post period s=%0d", s), per, 1 << s);
      check($sformatf("R5 post high time s=%0d", s), hi, (s == 0) ? 1 : ((1 << s) / 2));
    end

    // R8: change mid-run completes old period first
    tick(1); pin_cfg = word(20, 0, 3);
    sync(1); sync(1); sync(1);
    pin_cfg = word(2, 0, 3);
    gap(1, per, hi); check("R8 fb old period kept", per, 28);
    gap(1, per, hi); check("R8 fb new period", per, 10);
    sync(2); sync(2);
    pin_cfg = word(2, 0, 1);
    gap(2, per, hi); check("R8 post old period kept", per, 8);
    gap(2, per, hi); check("R8 post new period", per, 2);

    // R9: power-down holds all outputs low, config changes ignored
    tick(1); pwrdn = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (i == 10) pin_cfg = word(0, 0, 0);
      seen += int'(fb_pulse) + int'(fb_sq) + int'(out_pulse) + int'(out_sq);
    end
    check("R9 osc outputs during power-down", seen, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      tick(0);
      seen += int'(ref_pulse) + int'(ref_sq);
    end
    check("R9 ref outputs during power-down", seen, 0);

    // R10: restart from zero using the code present at release
    pin_cfg = word(6, 1, 2);
    for (int ch = 0; ch < 3; ch++) begin
      tick(ch); pwrdn = 1'b1;
      repeat (3) tick(ch);
      pwrdn = 1'b0;
      tick(ch);
      check($sformatf("R10 square high on first edge ch%0d", ch), int'(sq_of(ch)), 1);
      n = 1;
      for (int i = 0; i < 100; i++) begin
        if (pulse_of(ch)) break;
        tick(ch);
        n++;
      end
      check($sformatf("R10 first pulse edge ch%0d", ch), n, (ch == 0) ? 3 : ((ch == 1) ? 14 : 4));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule